// File: doc/BRIEF.md
# Serial ADC Host Read Controller

This block runs read transactions against a two-channel, 12-bit serial converter. It drives the converter's chip-select (`adc_cs_n`) and serial clock (`adc_sclk`) and samples the converter's data line (`adc_dout`). A one-cycle `start` pulse begins one transaction. The level of `int_mode` at that pulse picks one of two conversion styles. In internal-clock style the converter times its own conversion: the controller gives one falling clock edge, waits for the data line to go high, and then clocks out the result. In external-clock style the controller's serial clock drives the conversion while the result is shifted out.

The serial clock comes from a programmable divider, and a programmable setup delay separates the chip-select fall from the first clock movement. Each transaction captures a 16-bit frame. The controller checks the frame's three leading marker bits and then raises chip-select, which puts the converter back into power-down. It reports the channel ID and the 12 data bits with a one-cycle valid strobe. When the frame is malformed, or when the end-of-conversion flag never arrives, it gives a one-cycle error strobe instead. `adc_dout` must be synchronous to `clk`. The inputs `half_m1`, `setup_cyc` and `eoc_limit` must be held stable while `busy` is high.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While `adc_cs_n` falls, `adc_sclk` equals the `int_mode` value captured at `start`: 1 selects internal-clock style and 0 selects external-clock style. `adc_sclk` already holds that level in the cycle before the fall.
- R2: The first change of `adc_sclk` comes `setup_cyc`+1 clock cycles after `adc_cs_n` falls.
- R3: During readout, every high phase of `adc_sclk` lasts `half_m1`+1 clock cycles.
- R4: In internal-clock style, `adc_sclk` makes one falling edge and then stays low until `adc_dout` is sampled high. It then makes exactly 16 rising edges, for 17 falling edges in total, and no rising edge comes before the end-of-conversion flag.
- R5: In external-clock style, `adc_sclk` makes exactly 16 rising and 16 falling edges while `adc_cs_n` is low, with no wait for a flag.
- R6: `adc_dout` is sampled once at each rising edge of `adc_sclk`. The first bit sampled becomes frame bit 15. `res_chid` is frame bit 12 and `res_data` is frame bits 11..0.
- R7: `res_valid` pulses only when frame bits 15, 14 and 13 are all 1. Otherwise `res_err` pulses and `res_data` and `res_chid` read 0. The two strobes never pulse together.
- R8: In internal-clock style, the low wait after the first falling edge lasts at most `eoc_limit`+1 cycles. If `adc_dout` stays low for that whole wait, `res_err` pulses, no rising edge of `adc_sclk` occurs, and `adc_cs_n` returns high.
- R9: If `adc_dout` is first seen high in the last cycle of the wait window, the end-of-conversion flag wins over the timeout and the readout proceeds normally.
- R10: `adc_cs_n` rises in the same cycle as the one-cycle result strobe, with `adc_sclk` at 0 in that cycle.
- R11: A `start` that arrives while `busy` is high is ignored. Each transaction produces exactly one `adc_cs_n` fall, and the reported result belongs to the frame being read.
- R12: After reset, `adc_cs_n` is 1, `adc_sclk` is 0, and `busy`, `res_valid` and `res_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run a transaction |
| int_mode | input | 1 | Conversion style for the request: 1 internal clock, 0 external clock |
| half_m1 | input | DIV_W | Serial clock half period in clock cycles, minus one |
| setup_cyc | input | SET_W | Setup delay after the chip-select fall, minus one |
| eoc_limit | input | TO_W | Length of the end-of-conversion wait window, minus one |
| adc_dout | input | 1 | Serial data from the converter |
| adc_cs_n | output | 1 | Active-low chip-select to the converter |
| adc_sclk | output | 1 | Serial clock to the converter |
| busy | output | 1 | Transaction in progress |
| res_valid | output | 1 | One-cycle strobe: good result available |
| res_err | output | 1 | One-cycle strobe: malformed frame or timeout |
| res_chid | output | 1 | Channel ID of the last good result |
| res_data | output | 12 | Conversion data of the last good result |

## Verification
Two events can land on the same clock edge in internal-clock style: the end-of-conversion flag being seen, and the wait counter reaching `eoc_limit`. The bench's converter model counts clock edges from the first falling clock edge and raises its data line so that the flag appears exactly on the last edge of the window. It then repeats the run with the flag arriving one edge later. The first run must give a good result with 16 rising clock edges, and the second must give an error strobe with no rising edge at all.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    localparam int FRAME_BITS = 16;
    localparam int DATA_BITS  = 12;
    localparam int HDR_BITS   = 3;
    localparam int BIT_W      = $clog2(FRAME_BITS + 1);

    typedef enum logic [2:0] {
        S_IDLE,
        S_PREP,
        S_SETUP,
        S_IFALL,
        S_WAIT,
        S_READ,
        S_DONE
    } rd_state_e;

    typedef struct packed {
        logic                 chid;
        logic [DATA_BITS-1:0] data;
    } rd_result_t;

    function automatic logic hdr_good(input logic [FRAME_BITS-1:0] f);
        return &f[FRAME_BITS-1 -: HDR_BITS];
    endfunction

    function automatic rd_result_t frame_fields(input logic [FRAME_BITS-1:0] f);
        rd_result_t r;
        r.chid = f[DATA_BITS];
        r.data = f[DATA_BITS-1:0];
        return r;
    endfunction

endpackage

// File: rtl/adc_rd_clkdiv.sv
module adc_rd_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half_m1,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == half_m1);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_DIV_BOUND: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q <= half_m1)); // R3

endmodule

// File: rtl/adc_rd_frame.sv
module adc_rd_frame
    import adc_rd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  shift_en,
    input  logic                  bit_in,
    output logic [FRAME_BITS-1:0] frame_o,
    output logic                  hdr_ok_o
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            frame_o <= '0;
        end else if (shift_en) begin
            frame_o <= {frame_o[FRAME_BITS-2:0], bit_in};
        end
    end

    assign hdr_ok_o = hdr_good(frame_o);

    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!shift_en && !clr) |=> $stable(frame_o)); // R6

endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
    import adc_rd_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int SET_W = 8,
    parameter int TO_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 int_mode,
    input  logic [DIV_W-1:0]     half_m1,
    input  logic [SET_W-1:0]     setup_cyc,
    input  logic [TO_W-1:0]      eoc_limit,
    input  logic                 adc_dout,
    output logic                 adc_cs_n,
    output logic                 adc_sclk,
    output logic                 busy,
    output logic                 res_valid,
    output logic                 res_err,
    output logic                 res_chid,
    output logic [DATA_BITS-1:0] res_data
);

    localparam int CNT_W = (SET_W > TO_W) ? SET_W : TO_W;

    rd_state_e             state;
    logic                  cs_q;
    logic                  sclk_q;
    logic                  mode_q;
    logic [CNT_W-1:0]      cnt;
    logic [BIT_W-1:0]      bits;
    rd_result_t            res_q;
    logic                  tick;
    logic                  setup_end;
    logic                  take;
    logic [FRAME_BITS-1:0] frame;
    logic                  hdr_ok;

    assign setup_end = (state == S_SETUP) && (cnt == CNT_W'(setup_cyc));

    // A sample is taken on every clock edge that drives adc_sclk from 0 to 1.
    assign take = (setup_end && !mode_q)
               || ((state == S_WAIT) && adc_dout)
               || ((state == S_READ) && tick && !sclk_q);

    adc_rd_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .run     ((state == S_IFALL) || (state == S_READ)),
        .half_m1 (half_m1),
        .tick    (tick)
    );

    adc_rd_frame u_frame (
        .clk      (clk),
        .rst      (rst),
        .clr      ((state == S_IDLE) && start),
        .shift_en (take),
        .bit_in   (adc_dout),
        .frame_o  (frame),
        .hdr_ok_o (hdr_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            cs_q      <= 1'b1;
            sclk_q    <= 1'b0;
            mode_q    <= 1'b0;
            cnt       <= '0;
            bits      <= '0;
            res_valid <= 1'b0;
            res_err   <= 1'b0;
            res_q     <= '0;
        end else begin
            res_valid <= 1'b0;
            res_err   <= 1'b0;
            if (take) begin
                bits <= bits + 1'b1;
            end
            case (state)
                S_IDLE: begin
                    if (start) begin
                        mode_q <= int_mode;
                        sclk_q <= int_mode;
                        bits   <= '0;
                        state  <= S_PREP;
                    end
                end
                S_PREP: begin
                    cs_q  <= 1'b0;
                    cnt   <= '0;
                    state <= S_SETUP;
                end
                S_SETUP: begin
                    if (setup_end) begin
                        sclk_q <= !mode_q;
                        state  <= mode_q ? S_IFALL : S_READ;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_IFALL: begin
                    if (tick) begin
                        cnt   <= '0;
                        state <= S_WAIT;
                    end
                end
                S_WAIT: begin
                    if (adc_dout) begin
                        sclk_q <= 1'b1;
                        state  <= S_READ;
                    end else if (cnt == CNT_W'(eoc_limit)) begin
                        state <= S_DONE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_READ: begin
                    if (tick) begin
                        sclk_q <= !sclk_q;
                        if (sclk_q && (bits == BIT_W'(FRAME_BITS))) begin
                            state <= S_DONE;
                        end
                    end
                end
                S_DONE: begin
                    cs_q   <= 1'b1;
                    sclk_q <= 1'b0;
                    state  <= S_IDLE;
                    if (hdr_ok) begin
                        res_valid <= 1'b1;
                        res_q     <= frame_fields(frame);
                    end else begin
                        res_err <= 1'b1;
                        res_q   <= '0;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign adc_cs_n = cs_q;
    assign adc_sclk = sclk_q;
    assign busy     = (state != S_IDLE);
    assign res_chid = res_q.chid;
    assign res_data = res_q.data;

    AST_MODE_AT_CS_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_cs_n) |-> ((adc_sclk == mode_q) && $stable(adc_sclk))); // R1
    AST_SCLK_LOW_WAIT: assert property (@(posedge clk) disable iff (rst)
        (state == S_WAIT) |-> !adc_sclk); // R4
    AST_BITS_CAP: assert property (@(posedge clk) disable iff (rst)
        bits <= BIT_W'(FRAME_BITS)); // R5
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        $onehot0({res_valid, res_err})); // R7
    AST_VALID_HDR: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(hdr_ok)); // R7
    AST_CS_RISE_REPORT: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_cs_n) |-> ((res_valid || res_err) && !adc_sclk)); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (adc_cs_n && !adc_sclk)); // R12

endmodule

// File: tb/tb_adc_rd_ctrl.sv
module tb_adc_rd_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        int_mode = 1'b0;
    logic [7:0]  half_m1 = '0;
    logic [7:0]  setup_cyc = '0;
    logic [15:0] eoc_limit = 16'd200;
    logic        adc_dout = 1'b0;
    logic        adc_cs_n;
    logic        adc_sclk;
    logic        busy;
    logic        res_valid;
    logic        res_err;
    logic        res_chid;
    logic [11:0] res_data;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    adc_rd_ctrl dut (
        .clk(clk), .rst(rst), .start(start), .int_mode(int_mode),
        .half_m1(half_m1), .setup_cyc(setup_cyc), .eoc_limit(eoc_limit),
        .adc_dout(adc_dout), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
        .busy(busy), .res_valid(res_valid), .res_err(res_err),
        .res_chid(res_chid), .res_data(res_data)
    );

    // converter model and port monitor
    logic [15:0] dev_frame = '0;
    int  dev_idx, dev_conv_left, conv_n;
    bit  dev_mode, dev_converting, dev_eoc_done, dev_never;
    int  m_cs_falls, m_rises, m_falls, m_gap_cnt, m_first_gap, m_hi_len, m_rise_pre_eoc;
    bit  m_seen_change, m_mode_at_fall, m_stable_ok;
    bit  prev_cs, prev_sclk;

    always @(posedge clk) begin
        #1;
        if (rst) begin
            prev_cs   = 1'b1;
            prev_sclk = 1'b0;
            adc_dout  = 1'b0;
        end else begin
            if (prev_cs && !adc_cs_n) begin
                m_cs_falls++;
                m_mode_at_fall = adc_sclk;
                m_stable_ok    = (adc_sclk == prev_sclk);
                m_rises = 0; m_falls = 0; m_gap_cnt = 0; m_seen_change = 0;
                m_hi_len = 0; m_rise_pre_eoc = 0;
                dev_mode = adc_sclk; dev_idx = 0; dev_eoc_done = 0; dev_converting = 0;
                adc_dout = dev_mode ? 1'b0 : dev_frame[15];
            end else if (!adc_cs_n) begin
                if (!m_seen_change) begin
                    m_gap_cnt++;
                    if (adc_sclk != prev_sclk) begin
                        m_seen_change = 1;
                        m_first_gap   = m_gap_cnt;
                    end
                end
                if (!prev_sclk && adc_sclk) begin
                    m_rises++;
                    if (dev_mode && !dev_eoc_done) m_rise_pre_eoc++;
                end
                if (adc_sclk && m_rises == 2) m_hi_len++;
                if (prev_sclk && !adc_sclk) begin
                    m_falls++;
                    if (dev_mode && !dev_eoc_done && !dev_converting) begin
                        dev_converting = 1;
                        dev_conv_left  = conv_n;
                    end else if (dev_eoc_done || !dev_mode) begin
                        dev_idx++;
                        adc_dout = (dev_idx < 16) ? dev_frame[15-dev_idx] : 1'b0;
                    end
                end else if (dev_converting && !dev_never) begin
                    dev_conv_left--;
                    if (dev_conv_left == 0) begin
                        dev_converting = 0;
                        dev_eoc_done   = 1;
                        adc_dout       = 1'b1;
                    end
                end
            end else begin
                adc_dout = 1'b0;
            end
            prev_cs   = adc_cs_n;
            prev_sclk = adc_sclk;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_frame(input logic chid, input logic [11:0] data,
                                             input int bad_bit);
        logic [15:0] f;
        f = {3'b111, chid, data};
        if (bad_bit >= 13) f[bad_bit] = 1'b0;
        return f;
    endfunction

    task automatic run_txn(input bit mode, input logic [15:0] frame, input int cn,
                           input bit never, input int d, input int s, input int t,
                           input bit extra_start);
        bit exp_to, exp_ok, got_v, got_e, got_c, got_cs, got_sc;
        logic [11:0] got_d;
        int guard;
        int_mode = mode; half_m1 = 8'(d); setup_cyc = 8'(s); eoc_limit = 16'(t);
        dev_frame = frame; conv_n = cn; dev_never = never; m_cs_falls = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (extra_start) begin
            repeat (5) @(negedge clk);
            start = 1'b1; int_mode = ~mode;
            @(negedge clk);
            start = 1'b0; int_mode = mode;
        end
        guard = 0;
        while (!(res_valid || res_err) && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        got_v = res_valid; got_e = res_err; got_c = res_chid; got_d = res_data;
        got_cs = adc_cs_n; got_sc = adc_sclk;
        exp_to = mode && (never || cn > d + t + 1);
        exp_ok = !exp_to && (&frame[15:13]);
        chk("R10 cs_n high at strobe", int'(got_cs), 1);
        chk("R10 sclk low at strobe", int'(got_sc), 0);
        chk("R7 valid strobe", int'(got_v), int'(exp_ok));
        chk("R7 error strobe", int'(got_e), int'(!exp_ok));
        chk("R6 channel id", int'(got_c), exp_ok ? int'(frame[12]) : 0);
        chk("R6 data", int'(got_d), exp_ok ? int'(frame[11:0]) : 0);
        chk("R1 sclk level at cs fall", int'(m_mode_at_fall), int'(mode));
        chk("R1 sclk stable into cs fall", int'(m_stable_ok), 1);
        chk("R2 setup gap", m_first_gap, s + 1);
        chk("R11 one cs fall", m_cs_falls, 1);
        if (m_rises >= 2) chk("R3 high phase", m_hi_len, d + 1);
        if (exp_to) begin
            chk("R8 no rising edge on timeout", m_rises, 0);
            chk("R8 single falling edge", m_falls, 1);
        end else if (mode) begin
            chk("R4 rising edges", m_rises, 16);
            chk("R4 falling edges", m_falls, 17);
            chk("R4 no rise before flag", m_rise_pre_eoc, 0);
        end else begin
            chk("R5 rising edges", m_rises, 16);
            chk("R5 falling edges", m_falls, 16);
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int n_rand;
        void'($urandom(32'd4217));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R12 reset cs_n", int'(adc_cs_n), 1);
        chk("R12 reset sclk", int'(adc_sclk), 0);
        chk("R12 reset busy", int'(busy), 0);
        chk("R12 reset strobes", int'(res_valid || res_err), 0);

        // directed corners
        run_txn(1'b0, mk_frame(1'b1, 12'hA5C, -1), 1, 1'b0, 0, 0, 200, 1'b0);
        run_txn(1'b1, mk_frame(1'b0, 12'h3F1, -1), 4, 1'b0, 3, 5, 200, 1'b0);
        run_txn(1'b1, mk_frame(1'b1, 12'hFFF, -1), 1, 1'b1, 1, 2, 10, 1'b0);      // R8
        run_txn(1'b1, mk_frame(1'b1, 12'h5A5, -1), 1 + 7 + 1, 1'b0, 1, 1, 7, 1'b0); // R9 flag on last edge
        run_txn(1'b1, mk_frame(1'b1, 12'h5A5, -1), 1 + 7 + 2, 1'b0, 1, 1, 7, 1'b0); // R9 one edge late
        run_txn(1'b0, mk_frame(1'b0, 12'h001, 15), 1, 1'b0, 2, 1, 200, 1'b0);     // R7 bad marker
        run_txn(1'b1, mk_frame(1'b1, 12'h800, 13), 3, 1'b0, 0, 3, 200, 1'b0);     // R7 bad marker
        run_txn(1'b0, mk_frame(1'b1, 12'h7E7, -1), 1, 1'b0, 1, 0, 200, 1'b1);     // R11
        run_txn(1'b1, mk_frame(1'b0, 12'h0F0, -1), 6, 1'b0, 2, 4, 200, 1'b1);     // R11

        // constrained random mix
        n_rand = 40;
        for (int i = 0; i < n_rand; i++) begin
            bit m;
            int bad;
            m   = 1'($urandom % 2);
            bad = ($urandom % 5 == 0) ? (m ? 13 + int'($urandom % 2) : 13 + int'($urandom % 3)) : -1;
            run_txn(m, mk_frame(1'($urandom % 2), 12'($urandom), bad),
                    1 + int'($urandom % 30), 1'b0, int'($urandom % 4),
                    int'($urandom % 6), 200, 1'b0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule